// File: doc/BRIEF.md
# Link Status Capture Register

This block gathers health events from a serial receive path and exposes them as one read-only 32-bit status word. Single-cycle strobes mark a line-code decode error, a corrected stream alignment slip, a payload checksum mismatch, a receive buffer overflow and a transmit buffer overflow. A level input tracks whether the link is currently up. Decode errors are tallied in a saturating counter. Each of the other events, and any loss of link, sets a sticky flag.

A single clear pulse, driven by a separate control register, empties the counter and every sticky flag. It does not touch the live link bit. When an event lands in the same cycle as the clear, the event is kept. Software reads the word through a plain request/address port. The read answers one cycle later and returns zero for any address except the status offset.

Top module: `lsc_link_status`

## Requirements
- R1: After reset the status word reads as zero apart from bit 9, which follows the link-up input.
- R2: Bits 7:0 count decode error strobes, one per strobe, and return to zero on a clear pulse.
- R3: The count stops at 255 and stays there until a clear; it never wraps.
- R4: Bits 10, 11, 12 and 13 are sticky. They record, in that order, a corrected alignment slip, a checksum error, a receive overflow and a transmit overflow. Each stays 1 until a clear pulse.
- R5: Bit 8 is sticky. It sets on a high-to-low transition of the link-up input. It also sets when a clear pulse is issued while link-up is low.
- R6: Bit 9 reads the link-up input as it is in the read cycle and is never latched. A clear pulse does not affect it.
- R7: When an event and a clear pulse arrive in the same cycle, the event wins. The matching flag reads 1 after that cycle, or the count reads 1.
- R8: Bits 31:14 always read 0. A read at any byte address other than 0x0C returns all zeros.
- R9: A read request in one cycle gives rd_valid_o high in the next cycle. That response carries the word as it stood at the clock edge that captured the request. rd_valid_o is low whenever no request was made in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_err_i | input | 1 | Decode error strobe |
| sync_fix_i | input | 1 | Corrected alignment slip strobe |
| csum_err_i | input | 1 | Checksum error strobe |
| rx_ovf_i | input | 1 | Receive buffer overflow strobe |
| tx_ovf_i | input | 1 | Transmit buffer overflow strobe |
| link_up_i | input | 1 | Live link-up level |
| stat_clr_i | input | 1 | Clear pulse for counter and sticky flags |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read byte address |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 32 | Read response data |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, an 8-bit address and the status word at 0x0C. This is small enough to sweep every combination of the five strobes, the clear pulse and the link level, 128 cases, with a read and a check after each. It also lets the bench drive 300 decode errors to reach and hold the 255 ceiling, and read all 256 addresses to confirm decoding. Expected words are assembled arithmetically from a bench-side model of the counter, the flags and the link history.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Sticky flag indices inside the flag vector
  localparam int FL_LINK_DOWN = 0;
  localparam int FL_SYNC_FIX  = 1;
  localparam int FL_CSUM      = 2;
  localparam int FL_RX_OVF    = 3;
  localparam int FL_TX_OVF    = 4;
  localparam int NUM_FLAGS    = 5;
endpackage

// File: rtl/lsc_sat_counter.sv
module lsc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= inc ? {{(W-1){1'b0}}, 1'b1} : '0;
    end else if (inc && (count != MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/lsc_sticky_bank.sv
module lsc_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (clr)    flags[i] <= ev[i];
      else if (ev[i])  flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/lsc_link_watch.sv
module lsc_link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic clr,
  output logic down_ev
);
  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  // Falling edge of the level, or a clear issued while the link is down
  assign down_ev = (link_q & ~link_up) | (clr & ~link_up);
endmodule

// File: rtl/lsc_read_port.sv
module lsc_read_port #(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= (rd_addr == OFFSET) ? word : '0;
    end
  end
endmodule

// File: rtl/lsc_link_status.sv
module lsc_link_status #(
  parameter int          CNT_W  = 8,
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_err_i,
  input  logic              sync_fix_i,
  input  logic              csum_err_i,
  input  logic              rx_ovf_i,
  input  logic              tx_ovf_i,
  input  logic              link_up_i,
  input  logic              stat_clr_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  import lsc_pkg::*;

  localparam int USED_W = CNT_W + NUM_FLAGS + 1;
  localparam int RSVD_W = DATA_W - USED_W;

  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_FLAGS-1:0] ev;
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 down_ev;
  logic [DATA_W-1:0]    word;

  lsc_link_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up_i),
    .clr     (stat_clr_i),
    .down_ev (down_ev)
  );

  always_comb begin
    ev               = '0;
    ev[FL_LINK_DOWN] = down_ev;
    ev[FL_SYNC_FIX]  = sync_fix_i;
    ev[FL_CSUM]      = csum_err_i;
    ev[FL_RX_OVF]    = rx_ovf_i;
    ev[FL_TX_OVF]    = tx_ovf_i;
  end

  lsc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (dec_err_i),
    .clr   (stat_clr_i),
    .count (cnt_q)
  );

  lsc_sticky_bank #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .clr   (stat_clr_i),
    .flags (flags_q)
  );

  // Word layout: count, link-down flag, live link, then the other flags
  assign word = {{RSVD_W{1'b0}},
                 flags_q[FL_TX_OVF], flags_q[FL_RX_OVF],
                 flags_q[FL_CSUM],   flags_q[FL_SYNC_FIX],
                 link_up_i, flags_q[FL_LINK_DOWN], cnt_q};

  lsc_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (word),
    .rd_req   (rd_req_i),
    .rd_addr  (rd_addr_i),
    .rd_valid (rd_valid_o),
    .rd_data  (rd_data_o)
  );
endmodule

// File: rtl/lsc_link_status_chk.sv
module lsc_link_status_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int NF     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              dec_err,
  input logic              sync_fix,
  input logic              link_up,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [NF-1:0]     flags
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam int USED_W = CNT_W + NF + 1;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:USED_W] == '0));
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !clr) |=> (cnt == MAX));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && dec_err && cnt != MAX) |=> (cnt == $past(cnt) + 1'b1));
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && sync_fix) |=> flags[1]);
  a_r5_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_up) && !link_up) |=> flags[0]);
endmodule

bind lsc_link_status lsc_link_status_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .NF(lsc_pkg::NUM_FLAGS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (stat_clr_i),
  .dec_err  (dec_err_i),
  .sync_fix (sync_fix_i),
  .link_up  (link_up_i),
  .rd_req   (rd_req_i),
  .rd_valid (rd_valid_o),
  .rd_data  (rd_data_o),
  .cnt      (cnt_q),
  .flags    (flags_q)
);

// File: tb/tb_lsc_link_status.sv
module tb_lsc_link_status;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_err_i = 0, sync_fix_i = 0, csum_err_i = 0, rx_ovf_i = 0, tx_ovf_i = 0;
  logic        link_up_i = 0, stat_clr_i = 0, rd_req_i = 0;
  logic [7:0]  rd_addr_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  // Bench model
  int   m_cnt = 0;
  logic m_ld = 0, m_sy = 0, m_cs = 0, m_rx = 0, m_tx = 0;
  logic m_prev = 0;

  always #(PERIOD/2) clk = ~clk;

  lsc_link_status dut (
    .clk(clk), .rst_n(rst_n),
    .dec_err_i(dec_err_i), .sync_fix_i(sync_fix_i), .csum_err_i(csum_err_i),
    .rx_ovf_i(rx_ovf_i), .tx_ovf_i(tx_ovf_i), .link_up_i(link_up_i),
    .stat_clr_i(stat_clr_i), .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] exp_word();
    return (32'(m_cnt)) | (32'(m_ld) << 8) | (32'(link_up_i) << 9) |
           (32'(m_sy) << 10) | (32'(m_cs) << 11) | (32'(m_rx) << 12) |
           (32'(m_tx) << 13);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; mask bits: 0 dec, 1 sync, 2 csum, 3 rx, 4 tx
  task automatic step(input logic [4:0] m, input logic c, input logic l);
    logic down;
    @(negedge clk);
    {tx_ovf_i, rx_ovf_i, csum_err_i, sync_fix_i, dec_err_i} = m;
    stat_clr_i = c;
    link_up_i  = l;
    down = (m_prev && !l) || (c && !l);
    if (c) begin
      m_cnt = m[0] ? 1 : 0;
      m_ld = down; m_sy = m[1]; m_cs = m[2]; m_rx = m[3]; m_tx = m[4];
    end else begin
      if (m[0] && m_cnt < 255) m_cnt++;
      m_ld |= down; m_sy |= m[1]; m_cs |= m[2]; m_rx |= m[3]; m_tx |= m[4];
    end
    m_prev = l;
    @(negedge clk);
    {tx_ovf_i, rx_ovf_i, csum_err_i, sync_fix_i, dec_err_i} = '0;
    stat_clr_i = 0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a);
    logic [31:0] e;
    @(negedge clk);
    rd_req_i = 1; rd_addr_i = a;
    e = (a == 8'h0C) ? exp_word() : 32'h0;
    @(negedge clk);
    rd_req_i = 0;
    check({req, " R9 valid"}, 32'(rd_valid_o), 32'h1);
    check(req, rd_data_o, e);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    read_check("R1 reset", 8'h0C);
    @(negedge clk);
    check("R9 idle no valid", 32'(rd_valid_o), 32'h0);

    // R6 live link bit, no latching
    step(5'h0, 0, 1);
    read_check("R6 live up", 8'h0C);
    // R5 falling edge sets bit 8
    step(5'h0, 0, 0);
    read_check("R5 fall sets", 8'h0C);
    step(5'h0, 0, 1);
    read_check("R6 live back up, R5 stays", 8'h0C);
    step(5'h0, 1, 1);
    read_check("R6 clear keeps live, R5 cleared", 8'h0C);
    step(5'h0, 0, 0);
    step(5'h0, 1, 0);
    read_check("R5 clear while down", 8'h0C);

    // R2, R4, R7 sweep over all strobe/clear/link combinations
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 32; m++) begin
          step(5'(m), 1'(c), 1'(l));
          read_check(c ? "R7 event vs clear" : "R2 R4 accumulate", 8'h0C);
        end

    // R3 saturation
    step(5'h0, 1, 1);
    for (int i = 0; i < 300; i++) step(5'h01, 0, 1);
    read_check("R3 saturated", 8'h0C);
    step(5'h01, 0, 1);
    read_check("R3 held at max", 8'h0C);
    step(5'h00, 1, 1);
    read_check("R2 cleared", 8'h0C);

    // R8 address decode sweep with nonzero state
    step(5'h1F, 0, 1);
    step(5'h00, 0, 0);
    for (int a = 0; a < 256; a++) read_check("R8 decode", 8'(a));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule